// File: doc/BRIEF.md
# Quantized PWM Output Bank

This block drives a small set of pulse-width-modulated outputs from one reference clock. Each channel cuts time into quanta whose length comes from a 4-bit frequency code: a quantum is (32 − F) reference cycles, so it lasts 17 to 32 cycles. A period is always 1024 quanta long. The output is high for the first D+1 quanta of each period and low for the rest. A host programs the channels through a plain byte-wide register port with address, write data, write strobe and combinational read data. One shared register switches the channels on and off.

Each channel keeps a working copy of its settings. New frequency and duty values take effect only when the running period ends, so a period is never cut short. When a channel is switched on, its counters are cleared and a new period starts at once. When a channel is switched off, its output is held low. A zero duty cannot be encoded, and is obtained by switching the channel off.

Top module: `qpwm_bank`

## Requirements
- R1: After the synchronous active-low reset, every output is low and every mapped register reads zero.
- R2: A quantum lasts (32 − F) reference clock cycles, and every period lasts 1024 quanta whatever the duty setting.
- R3: In each period the output is high for the first D+1 quanta and then low. D = 1023 keeps the output high without a break while the channel is enabled.
- R4: Channel n owns two registers. Address 0x60+2n holds D[7:0]. Address 0x61+2n holds D[9:8] in bits [1:0] and F in bits [7:4]. Its bits [3:2] ignore writes and read zero.
- R5: The register at address 0x66 holds the enables, with bit n enabling channel n (n = 0..2). Its bits [7:3] ignore writes and read zero.
- R6: An output goes low in the same cycle that its enable bit clears, and it stays low while the bit is clear.
- R7: Setting an enable bit starts a fresh period. The output rises one cycle after the enable register updates, and the first high phase has its full length.
- R8: F and D written while a channel runs leave the current period unchanged and apply from the next period.
- R9: An access to an unmapped address reads zero, and a write to one changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle in which it is high |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pwm_out | output | 3 | One PWM output per channel |

## Verification
The waveform is checked by measuring the high and low run lengths at the outputs and comparing them with the values expected from F and D. Three patterns are used. F=15 with a mid-range duty exercises the shortest quantum. F=0 with the minimum duty shows both the longest quantum and a high phase of only one quantum. F=15 with D=1023 exercises the always-high case, where no falling edge may appear at the period boundary. A duty rewrite placed right after a rising edge separates a design that loads new settings at the boundary from one that applies them at once, and an enable issued in the middle of another channel's run shows that channels restart independently. Readback covers the reserved bits, the enable register and unmapped addresses.

// File: rtl/qpwm_pkg.sv
// Package for the quantized PWM bank: field widths and the per-channel
// configuration record shared by the register file and the channels.
package qpwm_pkg;

    // Width of the frequency code that selects the quantum length.
    localparam int FREQ_W       = 4;
    // Width of the duty code (high quanta minus one).
    localparam int DUTY_W       = 10;
    // Quantum length is QUANTUM_BASE minus the frequency code.
    localparam int QUANTUM_BASE = 32;
    // Width of the in-quantum cycle counter.
    localparam int QCNT_W       = $clog2(QUANTUM_BASE);

    // Settings of one channel as held in the registers.
    typedef struct packed {
        logic [FREQ_W-1:0] fcode;
        logic [DUTY_W-1:0] duty;
    } ch_cfg_t;

endpackage

// File: rtl/qpwm_regfile.sv
// Register file of the PWM bank.
// Holds the duty and frequency registers of every channel and the shared
// enable register, and returns read data combinationally.
// Assumes: every channel pair lies below 2**ADDR_W, N_CH <= DATA_W,
// DATA_W = 8 so the frequency code occupies bits [7:4] of the high byte.
module qpwm_regfile
    import qpwm_pkg::*;
#(
    parameter int                N_CH      = 3,
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h60,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h66
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  we_i,
    output logic [DATA_W-1:0]     rdata_o,
    output ch_cfg_t [N_CH-1:0]    cfg_o,
    output logic [N_CH-1:0]       en_o
);

    // Bit positions inside the high byte of a channel pair.
    localparam int F_LSB     = DATA_W - FREQ_W;
    localparam int DHI_W     = DUTY_W - 8;

    ch_cfg_t [N_CH-1:0] cfg_q;
    logic    [N_CH-1:0] en_q;

    // Reserved write bits are simply dropped; keep them visibly consumed.
    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    // Shared enable register: one bit per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (we_i && addr_i == EN_ADDR) begin
            en_q <= wdata_i[N_CH-1:0];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_CH; gi++) begin : g_chreg
            localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(BASE_ADDR + 2*gi);
            localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(BASE_ADDR + 2*gi + 1);

            // Low byte of the duty code for this channel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[gi].duty[7:0] <= '0;
                end else if (we_i && addr_i == A_LO) begin
                    cfg_q[gi].duty[7:0] <= wdata_i[7:0];
                end
            end

            // High duty bits and frequency code for this channel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[gi].duty[DUTY_W-1:8] <= '0;
                    cfg_q[gi].fcode            <= '0;
                end else if (we_i && addr_i == A_HI) begin
                    cfg_q[gi].duty[DUTY_W-1:8] <= wdata_i[DHI_W-1:0];
                    cfg_q[gi].fcode            <= wdata_i[DATA_W-1:F_LSB];
                end
            end
        end
    endgenerate

    // Readback multiplexer; unmapped addresses and reserved bits give zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == EN_ADDR) begin
            rdata_o = DATA_W'(en_q);
        end
        for (int i = 0; i < N_CH; i++) begin
            if (addr_i == ADDR_W'(BASE_ADDR + 2*i)) begin
                rdata_o = cfg_q[i].duty[7:0];
            end
            if (addr_i == ADDR_W'(BASE_ADDR + 2*i + 1)) begin
                rdata_o = '0;
                rdata_o[DATA_W-1:F_LSB] = cfg_q[i].fcode;
                rdata_o[DHI_W-1:0]      = cfg_q[i].duty[DUTY_W-1:8];
            end
        end
    end

    assign cfg_o = cfg_q;
    assign en_o  = en_q;

endmodule

// File: rtl/qpwm_tick.sv
// Quantum divider of one channel.
// Counts reference cycles and pulses tick_o on the last cycle of each
// quantum, where a quantum lasts (QUANTUM_BASE - fcode_i) cycles.
// Assumes: fcode_i is stable within a quantum (the caller only changes it
// on a tick or while clear_i is high).
module qpwm_tick
    import qpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [FREQ_W-1:0] fcode_i,
    output logic              tick_o
);

    logic [QCNT_W-1:0] qcnt_q;
    logic [QCNT_W-1:0] last_cnt;

    // Final count value of the current quantum.
    assign last_cnt = QCNT_W'(QUANTUM_BASE - 1) - QCNT_W'(fcode_i);

    // Quantum end strobe, suppressed while the channel restarts or is off.
    assign tick_o = !clear_i && (qcnt_q == last_cnt);

    // In-quantum cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            qcnt_q <= '0;
        end else if (tick_o) begin
            qcnt_q <= '0;
        end else begin
            qcnt_q <= qcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/qpwm_channel.sv
// One PWM channel.
// Keeps a working copy of its settings, loaded when the channel starts and
// at each period boundary, counts quanta through a period of 2**DUTY_W
// quanta and drives the output high while the quantum index <= duty.
// Assumes: en_i and cfg_i come from registers in the same clock domain.
module qpwm_channel
    import qpwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en_i,
    input  ch_cfg_t cfg_i,
    output logic    pwm_o
);

    logic              running_q;
    logic              start;
    logic              tick;
    logic              period_end;
    logic [DUTY_W-1:0] qidx_q;
    ch_cfg_t           act_q;

    // First enabled cycle: counters clear and settings load.
    assign start      = en_i && !running_q;
    assign period_end = tick && (qidx_q == '1);

    qpwm_tick u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!en_i || start),
        .fcode_i (act_q.fcode),
        .tick_o  (tick)
    );

    // Tracks whether the channel has passed its start cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
        end else begin
            running_q <= en_i;
        end
    end

    // Quantum index within the period, wrapping at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || start) begin
            qidx_q <= '0;
        end else if (tick) begin
            qidx_q <= qidx_q + 1'b1;
        end
    end

    // Working settings, refreshed only at a start or a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (start || period_end) begin
            act_q <= cfg_i;
        end
    end

    // Output: high for the first duty+1 quanta, forced low when disabled.
    assign pwm_o = en_i && running_q && (qidx_q <= act_q.duty);

endmodule

// File: rtl/qpwm_bank.sv
// Top of the quantized PWM bank.
// Connects the register file to N_CH independent channels.
// Assumes: one reference clock, synchronous active-low reset, and a host
// that holds reg_addr stable while it samples reg_rdata.
module qpwm_bank
    import qpwm_pkg::*;
#(
    parameter int                N_CH      = 3,
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h60,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [N_CH-1:0]   pwm_out
);

    ch_cfg_t [N_CH-1:0] cfg;
    logic    [N_CH-1:0] en_bits;

    qpwm_regfile #(
        .N_CH      (N_CH),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR),
        .EN_ADDR   (EN_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .we_i    (reg_we),
        .rdata_o (reg_rdata),
        .cfg_o   (cfg),
        .en_o    (en_bits)
    );

    genvar gc;
    generate
        for (gc = 0; gc < N_CH; gc++) begin : g_ch
            qpwm_channel u_ch (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (en_bits[gc]),
                .cfg_i (cfg[gc]),
                .pwm_o (pwm_out[gc])
            );
        end
    endgenerate

endmodule

// File: rtl/qpwm_checker.sv
// Property checker for qpwm_bank, attached with bind below.
// Watches the register port, the outputs and the internal enable bits.
module qpwm_checker #(
    parameter int                N_CH      = 3,
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h60,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h66
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [N_CH-1:0]   pwm_out,
    input logic [N_CH-1:0]   en_bits
);

    logic unmapped;
    logic in_pair;

    // Address classification from the parameters alone.
    assign in_pair  = (int'(reg_addr) >= int'(BASE_ADDR)) &&
                      (int'(reg_addr) <  int'(BASE_ADDR) + 2*N_CH);
    assign unmapped = !in_pair && (reg_addr != EN_ADDR);

    assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwm_out == '0));

    assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (reg_rdata == '0));

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && unmapped) |=> $stable(en_bits));

    assert_en_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == EN_ADDR) |-> (reg_rdata == DATA_W'(en_bits)));

    assert_hi_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pair && reg_addr[0] != BASE_ADDR[0]) |-> (reg_rdata[3:2] == 2'b00));

    genvar gk;
    generate
        for (gk = 0; gk < N_CH; gk++) begin : g_chk
            assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !en_bits[gk] |-> !pwm_out[gk]);

            assert_start_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(en_bits[gk]) && !reg_we) |=> pwm_out[gk]);
        end
    endgenerate

endmodule

bind qpwm_bank qpwm_checker #(
    .N_CH      (N_CH),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .EN_ADDR   (EN_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out),
    .en_bits   (en_bits)
);

// File: tb/qpwm_bank_tb_top.sv
// Scoreboard bench for qpwm_bank: the driver queues expected pulse shapes,
// the monitor measures them at the outputs and compares.
module qpwm_bank_tb_top;

    localparam int WATCHDOG = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic [2:0] pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    typedef struct {
        int    ch;
        int    high;
        int    low;
        string tag;
    } pulse_t;

    pulse_t sb_q[$];
    bit     mon_busy = 1'b0;

    always #2 clk = ~clk;

    qpwm_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic drain();
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    // Monitor: measures one high/low run per queued item and compares.
    initial begin
        bit at_rise;
        at_rise = 1'b0;
        forever begin
            pulse_t it;
            int hi, lo;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            mon_busy = 1'b1;
            if (!at_rise) wait_rise(it.ch);
            hi = 0;
            while (pwm_out[it.ch]) begin
                hi++;
                @(negedge clk);
            end
            lo = 0;
            while (!pwm_out[it.ch]) begin
                lo++;
                @(negedge clk);
            end
            at_rise = (sb_q.size() > 0);
            check(hi == it.high, {it.tag, " high run"}, hi, it.high);
            check(lo == it.low,  {it.tag, " low run"},  lo, it.low);
            mon_busy = 1'b0;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int hcount;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of outputs and registers.
        @(negedge clk);
        check(pwm_out == 3'b000, "R1 outputs after reset", pwm_out, 0);
        for (int a = 8'h60; a <= 8'h66; a++) rd_check(8'(a), 8'h00, "R1 register reset value");

        // R4: register layout and reserved bits.
        wr(8'h60, 8'h63);                     // ch0 D=99
        wr(8'h61, 8'hF0);                     // ch0 F=15
        wr(8'h63, 8'h3E);                     // ch1 F=3, D[9:8]=2, bits 3:2 set
        rd_check(8'h60, 8'h63, "R4 ch0 duty low byte");
        rd_check(8'h61, 8'hF0, "R4 ch0 high byte");
        rd_check(8'h63, 8'h32, "R4 ch1 reserved bits read zero");

        // R7 + R2 + R3: enable ch0, first pulse full length from a fresh start.
        sb_q.push_back('{0, 100*17, 1024*17 - 100*17, "R7 R2 R3 ch0 F=15 D=99"});
        wr(8'h66, 8'hF9);                     // upper bits ignored
        check(pwm_out[0] == 1'b0, "R7 start cycle low", pwm_out[0], 0);
        @(negedge clk);
        check(pwm_out[0] == 1'b1, "R7 output rises after enable", pwm_out[0], 1);
        rd_check(8'h66, 8'h01, "R5 enable readback upper bits zero");
        drain();

        // R2 + R3: ch2 with the longest quantum and a one-quantum duty.
        wr(8'h64, 8'h00);
        wr(8'h65, 8'h00);
        sb_q.push_back('{2, 32, 1024*32 - 32, "R2 R3 ch2 F=0 D=0"});
        wr(8'h66, 8'h05);
        drain();

        // R3: ch1 with D=1023 stays high across a period boundary.
        wr(8'h62, 8'hFF);
        wr(8'h63, 8'hF3);
        wr(8'h66, 8'h07);
        @(negedge clk);
        hcount = 0;
        for (int i = 0; i < 1024*17 + 50; i++) begin
            if (pwm_out[1]) hcount++;
            @(negedge clk);
        end
        check(hcount == 1024*17 + 50, "R3 ch1 full duty never low", hcount, 1024*17 + 50);

        // R8: duty rewrite right after a rise applies from the next period.
        sb_q.push_back('{0, 100*17, 1024*17 - 100*17, "R8 current period unchanged"});
        sb_q.push_back('{0, 50*17,  1024*17 - 50*17,  "R8 next period updated"});
        wait_rise(0);
        reg_addr  = 8'h60;
        reg_wdata = 8'h31;                    // D=49
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
        drain();

        // R6: disable ch0 in its high phase; output low at once and stays low.
        wait_rise(0);
        wr(8'h66, 8'h06);
        check(pwm_out[0] == 1'b0, "R6 low after disable", pwm_out[0], 0);
        hcount = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pwm_out[0]) hcount++;
        end
        check(hcount == 0, "R6 stays low while disabled", hcount, 0);
        check(pwm_out[1] == 1'b1, "R6 other channel unaffected", pwm_out[1], 1);

        // R9: unmapped accesses.
        wr(8'h67, 8'hFF);
        wr(8'h5F, 8'hFF);
        wr(8'h80, 8'h00);
        rd_check(8'h67, 8'h00, "R9 unmapped read above");
        rd_check(8'h5F, 8'h00, "R9 unmapped read below");
        rd_check(8'h66, 8'h06, "R9 enables unchanged");
        rd_check(8'h60, 8'h31, "R9 ch0 duty unchanged");
        @(negedge clk);
        check(pwm_out[0] == 1'b0, "R9 output unchanged", pwm_out[0], 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule